// File: doc/BRIEF.md
# Two-Lane Pattern and Dictionary Line Decompressor

This block turns one compressed cache line back into its sixteen 32-bit words and delivers them as a stream of two words per transfer. The caller places the whole compressed image in a wide buffer, most significant bit first. It then pulses a start strobe for one clock while the block is idle. From that point the block walks the image, eight word pairs in all. For each word it reads a short prefix code. It rebuilds the word from zero bytes, from literal bytes carried in the stream, or from bytes of an earlier word held in a small first-in first-out dictionary. That dictionary is rebuilt word by word in exactly the order the compressor filled its own copy.

The dictionary holds sixteen 32-bit entries and is cleared when each line starts. Both codewords of a pair are parsed in the same cycle. The length of the first codeword comes from its prefix alone, which gives the start of the second codeword. If the second word names the slot that the first word is filling in that same pair, it sees the new word. A line flagged as incompressible bypasses decoding and is passed out as sixteen raw words.

The output side is valid/ready. A pair is transferred on a clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the pair and its `out_last` flag stay unchanged and the dictionary does not move. `out_valid` never depends on `out_ready`.

Top module: `cpd_line_decomp`

## Requirements
- R1: Codewords are read MSB first. The prefix decides the form and total length: `00` zero word (2 bits); `01` followed by a 32-bit verbatim word (34 bits); `10` followed by a 4-bit slot index, full match (6 bits); `1100` followed by index and 16 literal bits (24 bits); `1101` followed by 8 literal bits (12 bits); `1110` followed by index and 8 literal bits (16 bits). The prefix `1111` is reserved and decodes as a zero word of 4 bits.
- R2: A `00` codeword yields 0x00000000. A `1101` codeword yields its literal in bits 7:0, with all upper bytes zero.
- R3: A full match yields the indexed entry unchanged. A `1100` codeword yields entry bits 31:16 over the 16-bit literal. A `1110` codeword yields entry bits 31:8 over the 8-bit literal.
- R4: A `01` codeword yields its 32 payload bits unchanged.
- R5: Every rebuilt word from a `01`, `10`, `1100` or `1110` codeword enters the dictionary at the next slot, starting at slot 0 for each line. Zero-form words are not inserted. All slots read as zero after a line starts.
- R6: When the second word of a pair indexes the slot that the first word of that pair is filling, it is rebuilt from the first word.
- R7: Each transfer carries two words. `out_word0` is the earlier word in line order. A line takes eight transfers, and with `out_ready` held high these run in eight consecutive cycles.
- R8: `out_last` is high only with the eighth pair of a line, and `out_valid` is low on the cycle after that pair is taken. Bits after the sixteenth codeword have no effect.
- R9: With `in_raw` high at start, the buffer's top 512 bits are output as sixteen words, the top 32 bits first, and no codes are parsed.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, both words and `out_last` hold their values on the next cycle.
- R11: A start strobe while a line is in progress is ignored, and the current line completes unchanged.
- R12: After reset, `out_valid` and `out_last` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_start | input | 1 | Start strobe, taken only while idle |
| in_raw | input | 1 | Line is stored uncompressed |
| in_line | input | 544 | Compressed line image, first codeword at the MSB |
| out_ready | input | 1 | Consumer accepts the current pair |
| out_valid | output | 1 | A word pair is presented |
| out_word0 | output | 32 | Earlier word of the pair |
| out_word1 | output | 32 | Later word of the pair |
| out_last | output | 1 | Pair is the final one of the line |

## Verification
Two functions can land in the same cycle: the first lane writing a new dictionary entry, and the second lane reading that very slot. Some pairs in the tests make the first word a verbatim or partial-match insertion and make the second word index the slot being written. Those words are judged against a dictionary model kept in the bench. Back-pressure adds a second overlap: a stalled pair must not advance the dictionary. Toggling `out_ready` during a line whose later words depend on earlier entries shows any drift as wrong words.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
  localparam int WORD_W     = 32;
  localparam int IDX_W      = 4;
  localparam int DICT_DEPTH = 1 << IDX_W;
  localparam int CW_MAX     = 2 + WORD_W;
  localparam int LEN_W      = 6;

  typedef struct packed {
    logic [LEN_W-1:0]  len;    // total codeword bits
    logic [IDX_W-1:0]  idx;    // dictionary slot
    logic [WORD_W-1:0] lit;    // literal bytes in place, zero elsewhere
    logic [WORD_W-1:0] dmask;  // bytes taken from the dictionary entry
    logic              ins;    // word enters the dictionary
  } cw_t;
endpackage

// File: rtl/cpd_cw_dec.sv
module cpd_cw_dec
  import cpd_pkg::*;
(
  input  logic [CW_MAX-1:0] win,
  output cw_t               cw
);
  localparam int IDX_HI_S = CW_MAX - 3;          // index after a 2-bit prefix
  localparam int IDX_HI_L = CW_MAX - 5;          // index after a 4-bit prefix
  localparam int LIT_HI_L = CW_MAX - 5 - IDX_W;  // literal after prefix + index

  // Length path: prefix bits only, so lane 1 can locate its window early.
  always_comb begin
    unique casez (win[CW_MAX-1 -: 4])
      4'b00??: cw.len = LEN_W'(2);
      4'b01??: cw.len = LEN_W'(CW_MAX);
      4'b10??: cw.len = LEN_W'(2 + IDX_W);
      4'b1100: cw.len = LEN_W'(4 + IDX_W + 16);
      4'b1101: cw.len = LEN_W'(4 + 8);
      4'b1110: cw.len = LEN_W'(4 + IDX_W + 8);
      default: cw.len = LEN_W'(4);  // reserved prefix
    endcase
  end

  // Payload path.
  always_comb begin
    cw.idx   = '0;
    cw.lit   = '0;
    cw.dmask = '0;
    cw.ins   = 1'b0;
    unique casez (win[CW_MAX-1 -: 4])
      4'b01??: begin
        cw.lit = win[WORD_W-1:0];
        cw.ins = 1'b1;
      end
      4'b10??: begin
        cw.idx   = win[IDX_HI_S -: IDX_W];
        cw.dmask = 32'hFFFF_FFFF;
        cw.ins   = 1'b1;
      end
      4'b1100: begin
        cw.idx   = win[IDX_HI_L -: IDX_W];
        cw.lit   = {16'h0, win[LIT_HI_L -: 16]};
        cw.dmask = 32'hFFFF_0000;
        cw.ins   = 1'b1;
      end
      4'b1101: cw.lit = {24'h0, win[IDX_HI_L -: 8]};
      4'b1110: begin
        cw.idx   = win[IDX_HI_L -: IDX_W];
        cw.lit   = {24'h0, win[LIT_HI_L -: 8]};
        cw.dmask = 32'hFFFF_FF00;
        cw.ins   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cpd_dict.sv
module cpd_dict #(
  parameter int DEPTH = 16,
  parameter int W     = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     we_a,
  input  logic [W-1:0]             wd_a,
  input  logic                     we_b,
  input  logic [W-1:0]             wd_b,
  input  logic [$clog2(DEPTH)-1:0] ra_a,
  input  logic [$clog2(DEPTH)-1:0] ra_b,
  output logic [W-1:0]             rd_a,
  output logic [W-1:0]             rd_b,
  output logic [$clog2(DEPTH)-1:0] head
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] slot_b;

  assign slot_b = head + AW'(we_a);
  assign rd_a   = mem[ra_a];
  assign rd_b   = mem[ra_b];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (clr) begin
      head <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (we_a) mem[head]   <= wd_a;
      if (we_b) mem[slot_b] <= wd_b;
      head <= head + AW'(we_a) + AW'(we_b);
    end
  end

  // R5: a cleared dictionary reads zero on every slot
  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rd_a == '0 && rd_b == '0));
endmodule

// File: rtl/cpd_line_decomp.sv
module cpd_line_decomp
  import cpd_pkg::*;
#(
  parameter int LINE_WORDS = 16,
  parameter int BUF_W      = LINE_WORDS * CW_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_start,
  input  logic              in_raw,
  input  logic [BUF_W-1:0]  in_line,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word0,
  output logic [WORD_W-1:0] out_word1,
  output logic              out_last
);
  localparam int PAIRS = LINE_WORDS / 2;
  localparam int PC_W  = $clog2(PAIRS);
  localparam int SH_W  = LEN_W + 1;

  logic             busy, raw_q, fire, take;
  logic [BUF_W-1:0] buf_q;
  logic [PC_W-1:0]  pair_cnt;
  logic [SH_W-1:0]  shamt;

  logic [CW_MAX-1:0] win_a, win_b;
  cw_t               cw_a, cw_b;
  logic [WORD_W-1:0] rd_a, rd_b, ent_b, word_a, word_b;
  logic [IDX_W-1:0]  head;

  assign take = in_start && !busy;
  assign fire = busy && out_ready;

  // Lane 0 sits at the top; lane 1 starts where lane 0's prefix says it ends.
  assign win_a = buf_q[BUF_W-1 -: CW_MAX];
  assign win_b = buf_q[BUF_W-1-cw_a.len -: CW_MAX];

  cpd_cw_dec u_dec_a (.win(win_a), .cw(cw_a));
  cpd_cw_dec u_dec_b (.win(win_b), .cw(cw_b));

  cpd_dict #(.DEPTH(DICT_DEPTH), .W(WORD_W)) u_dict (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (take),
    .we_a (fire && !raw_q && cw_a.ins),
    .wd_a (word_a),
    .we_b (fire && !raw_q && cw_b.ins),
    .wd_b (word_b),
    .ra_a (cw_a.idx),
    .ra_b (cw_b.idx),
    .rd_a (rd_a),
    .rd_b (rd_b),
    .head (head)
  );

  assign word_a = (rd_a & cw_a.dmask) | cw_a.lit;
  // Same-pair forwarding: lane 1 reads the slot lane 0 is filling.
  assign ent_b  = (cw_a.ins && cw_b.idx == head) ? word_a : rd_b;
  assign word_b = (ent_b & cw_b.dmask) | cw_b.lit;

  assign shamt = raw_q ? SH_W'(2 * WORD_W) : (SH_W'(cw_a.len) + SH_W'(cw_b.len));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      raw_q    <= 1'b0;
      buf_q    <= '0;
      pair_cnt <= '0;
    end else if (take) begin
      busy     <= 1'b1;
      raw_q    <= in_raw;
      buf_q    <= in_line;
      pair_cnt <= '0;
    end else if (fire) begin
      buf_q    <= buf_q << shamt;
      pair_cnt <= pair_cnt + 1'b1;
      if (pair_cnt == PC_W'(PAIRS - 1)) busy <= 1'b0;
    end
  end

  assign out_valid = busy;
  assign out_last  = busy && (pair_cnt == PC_W'(PAIRS - 1));
  assign out_word0 = raw_q ? buf_q[BUF_W-1 -: WORD_W] : word_a;
  assign out_word1 = raw_q ? buf_q[BUF_W-1-WORD_W -: WORD_W] : word_b;

  // Checker: transfers seen since the last accepted start.
  logic [PC_W:0] seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      seen <= '0;
    else if (take)                   seen <= '0;
    else if (out_valid && out_ready) seen <= seen + 1'b1;
  end

  // R10: a stalled pair holds steady
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word0)
                                   && $stable(out_word1) && $stable(out_last)));
  // R8: last flag only travels with a valid pair
  a_r8_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  // R8: stream stops after the last pair is taken
  a_r8_stop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !out_valid);
  // R7: the last flag arrives after exactly PAIRS-1 earlier transfers
  a_r7_pair_count: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (seen == (PC_W + 1)'(PAIRS - 1)));
  // R11: a start while busy does not restart the line
  a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (in_start && out_valid && !out_ready) |=> $stable(out_word0));
endmodule

// File: tb/cpd_line_decomp_tb.sv
module cpd_line_decomp_tb;
  localparam int BW = 544;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_start = 1'b0;
  logic          in_raw = 1'b0;
  logic [BW-1:0] in_line = '0;
  logic          out_ready = 1'b0;
  logic          out_valid, out_last;
  logic [31:0]   out_word0, out_word1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cpd_line_decomp u_dut (
    .clk(clk), .rst_n(rst_n), .in_start(in_start), .in_raw(in_raw),
    .in_line(in_line), .out_ready(out_ready), .out_valid(out_valid),
    .out_word0(out_word0), .out_word1(out_word1), .out_last(out_last)
  );

  // Line builder and reference dictionary
  logic [BW-1:0] pk;
  int            pos;
  logic [31:0]   exp_w [16];
  int            nexp;
  logic [31:0]   ref_d [16];
  int            ref_h;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic begin_line();
    pk = '1; pos = 0; nexp = 0; ref_h = 0;
    for (int i = 0; i < 16; i++) ref_d[i] = '0;
  endtask

  task automatic put(input logic [33:0] v, input int n);
    for (int i = 0; i < n; i++) pk[BW-1-pos-i] = v[n-1-i];
    pos += n;
  endtask

  task automatic push(input logic [31:0] w, input bit ins);
    exp_w[nexp] = w; nexp++;
    if (ins) begin ref_d[ref_h] = w; ref_h = (ref_h + 1) % 16; end
  endtask

  task automatic e_zero();                 put(0, 2); push(32'h0, 0); endtask
  task automatic e_zbyte(input logic [7:0] b); put(4'b1101, 4); put(b, 8); push({24'h0, b}, 0); endtask
  task automatic e_verb(input logic [31:0] w); put(2'b01, 2); put(w, 32); push(w, 1); endtask
  task automatic e_full(input logic [3:0] i);  put(2'b10, 2); put(i, 4); push(ref_d[i], 1); endtask
  task automatic e_half(input logic [3:0] i, input logic [15:0] l);
    put(4'b1100, 4); put(i, 4); put(l, 16); push({ref_d[i][31:16], l}, 1);
  endtask
  task automatic e_three(input logic [3:0] i, input logic [7:0] l);
    put(4'b1110, 4); put(i, 4); put(l, 8); push({ref_d[i][31:8], l}, 1);
  endtask
  task automatic e_rawword(input logic [31:0] w); put(w, 32); push(w, 0); endtask

  // stall: 0 = ready always, 1 = alternate, 2 = two low then one high
  task automatic run_line(input bit raw, input int stall, input bit mid_start, input string req);
    int p = 0, cyc = 0;
    logic [31:0] h0, h1; logic hl; bit held = 0;
    @(negedge clk);
    in_line = pk; in_raw = raw; in_start = 1'b1;
    @(negedge clk);
    in_start = 1'b0; in_line = ~pk;
    while (p < 8 && cyc < 200) begin
      out_ready = (stall == 0) ? 1'b1 : (stall == 1) ? cyc[0] : (cyc % 3 == 2);
      if (mid_start) in_start = (p == 3);
      #1;
      if (held) begin
        check(out_valid && out_word0 == h0 && out_word1 == h1 && out_last == hl,
              "R10 hold", {out_word0, out_word1}, {h0, h1});
        held = 0;
      end
      if (out_valid && out_ready) begin
        check(out_word0 == exp_w[2*p],   {req, " word0"}, {32'h0, out_word0}, {32'h0, exp_w[2*p]});
        check(out_word1 == exp_w[2*p+1], {req, " word1"}, {32'h0, out_word1}, {32'h0, exp_w[2*p+1]});
        check(out_last == (p == 7), "R8 last flag", {63'h0, out_last}, {63'h0, p == 7});
        p++;
      end else if (out_valid) begin
        h0 = out_word0; h1 = out_word1; hl = out_last; held = 1;
      end else begin
        check(1'b0, "R7 valid gap", 0, 1);
      end
      cyc++;
      @(negedge clk);
    end
    in_start = 1'b0; out_ready = 1'b0;
    #1;
    check(!out_valid, "R8 R11 idle after line", {63'h0, out_valid}, 0);
  endtask

  task automatic t_reset();
    #1;
    check(!out_valid && !out_last, "R12 reset idle", {62'h0, out_valid, out_last}, 0);
  endtask

  task automatic t_mixed();
    begin_line();
    e_verb(32'hA1B2C3D4); e_zero();            // R4 R2
    e_zbyte(8'h5A);       e_full(0);           // R2 R3
    e_half(0, 16'h1234);  e_three(1, 8'h77);   // R3
    e_verb(32'hDEADBEEF); e_zero();
    e_zero();             e_three(2, 8'h01);
    e_half(3, 16'hFFFF);  e_zbyte(8'h00);
    e_full(5);            e_verb(32'h00000001);
    e_full(7);            e_zero();
    run_line(0, 0, 0, "R1 R3 mixed");
  endtask

  task automatic t_same_pair();
    begin_line();
    e_verb(32'hCAFEF00D); e_full(0);           // R6 lane 1 reads slot 0 being filled
    e_verb(32'h13572468); e_half(2, 16'hABCD); // slot 2 written then read
    e_zero();             e_zbyte(8'h99);      // no insertion (R5)
    e_three(3, 8'h42);    e_three(4, 8'h43);   // R6 chained
    e_verb(32'h80000000); e_full(6);
    e_zero();             e_zero();
    e_half(7, 16'h0000);  e_full(8);
    e_verb(32'h7FFFFFFF); e_three(10, 8'hEE);
    run_line(0, 0, 0, "R6 same pair");
  endtask

  task automatic t_clear();
    begin_line();
    e_full(0); e_full(5);                       // R5 fresh line: entries read zero
    e_zero();  e_verb(32'h11112222);
    e_full(2); e_half(1, 16'h3333);             // zero words skipped, slot 2 holds verbatim
    e_zbyte(8'h10); e_three(3, 8'h44);
    for (int i = 0; i < 8; i++) e_full(4'(i));
    run_line(0, 2, 0, "R5 R10 clear and stall");
  endtask

  task automatic t_raw();
    begin_line();
    for (int i = 0; i < 16; i++) e_rawword(32'h01000000 * (i + 1) + 32'h00010203 * i);
    run_line(1, 1, 0, "R9 raw");
  endtask

  task automatic t_busy_start();
    begin_line();
    for (int i = 0; i < 8; i++) begin
      e_verb(32'h0F0F0000 + 32'(i)); e_three(4'(2*i), 8'(i));
    end
    run_line(0, 0, 1, "R11 start while busy");
  endtask

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_mixed();
    t_same_pair();
    t_clear();
    t_raw();
    t_busy_start();
    t_mixed();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule